// File: doc/BRIEF.md
# Three-Wire Configuration Register Port

This block is a slave serial port that lets a host program and read back a bank of eight configuration words, 11 bits each, over three lines: a serial clock, a serial data input and an active-low load strobe. All three lines are oversampled by the core clock through a short synchronizer chain. Their edges are then detected, so the serial clock must run well below the core clock. A frame opens when the load line falls. Sixteen bits follow on rising serial-clock edges: a 5-bit header, then an 11-bit data word.

The header holds the register address in three bits, least significant first, then a read flag and then a test flag. The data bits follow, also least significant first. A write frame only fills a shadow word. The live register takes the new value when the load line rises, and only if the frame was complete and valid. Fields narrower than 11 bits are masked, and the operation word keeps its fixed bits. A read frame instead drives the addressed live word out on the serial data output, changing on falling serial-clock edges. The output enable marks when the pad should drive.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset, register 0 holds 0x080 and registers 1 to 7 hold zero, and the output enable is low.
- R2: Bits are taken on rising serial-clock edges while the load line is low, in the order A0, A1, A2, RNW, TEST, D0..D10. The register index is A0 + 2*A1 + 4*A2, and the data word has D0 as bit 0.
- R3: A write changes no live register while the frame is in progress. The value appears only after the load line rises.
- R4: Register 1 keeps bits 9:0, register 2 keeps bits 7:0, register 3 keeps all 11 bits, and registers 4 to 7 keep bits 5:0. Bits that are not kept are stored and read as zero.
- R5: In register 0, bits 5:0 are writable, bit 7 always reads one, and bits 6, 8, 9 and 10 always read zero.
- R6: A frame with fewer than 16 rising serial-clock edges before the load line rises commits nothing.
- R7: A frame with TEST = 1 neither commits a write nor drives read data.
- R8: With RNW = 1, the fifth falling serial-clock edge of the frame drives bit 0 of the addressed live register. Each later falling edge advances one bit, and the read changes no register.
- R9: The output enable is high only during a read frame, from its fifth falling edge until the load line rises. While the enable is low, the data output is zero.
- R10: Rising edges after the sixteenth in a frame are ignored, and the first sixteen bits decide the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host, idle low |
| sl | input | 1 | Load strobe, low during a frame; its rising edge commits |
| sdata_in | input | 1 | Serial data from the host |
| sdata_out | output | 1 | Serial read data |
| sdata_oe | output | 1 | High while the read data should be driven onto the pad |
| cfg_q | output | 88 | Live registers, register n at bits [11n+10:11n] |

## Verification
Write frames are sent with alternating bit patterns and with all-ones words to several addresses. The alternating patterns show up any swap of bit order or address order. The all-ones words show the masking of each register and the fixed bits of register 0. Short frames, frames with the test flag set and over-long frames are each sent after a known value is in place, to tell a discarded frame from one that was partly or wrongly applied. Read frames of known contents check the bit order, the exact falling edge where output starts, and that the enable is held only inside the read.

// File: rtl/scfg_pkg.sv
package scfg_pkg;

    localparam int NUM_REGS  = 8;
    localparam int ADDR_W    = $clog2(NUM_REGS);
    localparam int DATA_W    = 11;
    localparam int HDR_W     = ADDR_W + 2;
    localparam int FRAME_LEN = HDR_W + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // header as shifted in: address in the low bits, then read flag, then test flag
    typedef struct packed {
        logic  test;
        logic  rnw;
        addr_t addr;
    } hdr_t;

    // synchronized line levels and detected edges
    typedef struct packed {
        logic sdi;
        logic sl_low;
        logic sl_fall;
        logic sl_rise;
        logic sck_fall;
        logic sck_rise;
    } sev_t;

    localparam word_t OP_FIXED_ONES = word_t'(11'h080);

    function automatic word_t keep_mask(addr_t a);
        case (a)
            addr_t'(0): keep_mask = word_t'(11'h03F);
            addr_t'(1): keep_mask = word_t'(11'h3FF);
            addr_t'(2): keep_mask = word_t'(11'h0FF);
            addr_t'(3): keep_mask = word_t'(11'h7FF);
            default:    keep_mask = word_t'(11'h03F);
        endcase
    endfunction

    function automatic word_t fixed_ones(addr_t a);
        fixed_ones = (a == addr_t'(0)) ? OP_FIXED_ONES : '0;
    endfunction

    function automatic word_t reset_word(addr_t a);
        reset_word = fixed_ones(a);
    endfunction

endpackage

// File: rtl/scfg_sync.sv
module scfg_sync
    import scfg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic sl,
    input  logic sdi,
    output sev_t ev
);
    // packed lane order {sdi, sl, sck}; idle is sl high, others low
    localparam logic [2:0] IDLE = 3'b010;

    logic [2:0] stg [STAGES];
    logic [2:0] prv;
    logic [2:0] cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= IDLE;
            prv <= IDLE;
        end else begin
            for (int i = STAGES - 1; i > 0; i--) stg[i] <= stg[i-1];
            stg[0] <= {sdi, sl, sck};
            prv    <= stg[STAGES-1];
        end
    end

    assign cur = stg[STAGES-1];

    always_comb begin
        ev.sck_rise = cur[0] & ~prv[0];
        ev.sck_fall = ~cur[0] & prv[0];
        ev.sl_rise  = cur[1] & ~prv[1];
        ev.sl_fall  = ~cur[1] & prv[1];
        ev.sl_low   = ~cur[1];
        ev.sdi      = cur[2];
    end

endmodule

// File: rtl/scfg_frame.sv
module scfg_frame
    import scfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  sev_t             ev,
    output hdr_t             hdr,
    output word_t            shadow,
    output logic [CNT_W-1:0] cnt
);
    logic [HDR_W-1:0] hdr_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_sr <= '0;
            shadow <= '0;
            cnt    <= '0;
        end else if (ev.sl_fall) begin
            cnt <= '0;
        end else if (ev.sck_rise && ev.sl_low && cnt < CNT_W'(FRAME_LEN)) begin
            // first-sent bit ends up at bit 0 after the field is full
            if (cnt < CNT_W'(HDR_W)) hdr_sr <= {ev.sdi, hdr_sr[HDR_W-1:1]};
            else                     shadow <= {ev.sdi, shadow[DATA_W-1:1]};
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign hdr = hdr_t'(hdr_sr);

endmodule

// File: rtl/scfg_regbank.sv
module scfg_regbank
    import scfg_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  sev_t                       ev,
    input  hdr_t                       hdr,
    input  word_t                      shadow,
    input  logic [CNT_W-1:0]           cnt,
    output word_t                      rd_word,
    output logic [NUM_REGS*DATA_W-1:0] cfg_q
);
    word_t live [NUM_REGS];
    logic  commit;

    assign commit = ev.sl_rise && (cnt == CNT_W'(FRAME_LEN)) && !hdr.rnw && !hdr.test;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                live[g] <= reset_word(addr_t'(g));
            else if (commit && hdr.addr == addr_t'(g))
                live[g] <= (shadow & keep_mask(addr_t'(g))) | fixed_ones(addr_t'(g));
        end
        assign cfg_q[g*DATA_W +: DATA_W] = live[g];
    end

    assign rd_word = live[hdr.addr];

endmodule

// File: rtl/scfg_readout.sv
module scfg_readout
    import scfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  sev_t             ev,
    input  hdr_t             hdr,
    input  logic [CNT_W-1:0] cnt,
    input  word_t            rd_word,
    output logic             sdo,
    output logic             oe
);
    word_t sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
            oe <= 1'b0;
        end else if (ev.sl_rise || ev.sl_fall) begin
            sh <= '0;
            oe <= 1'b0;
        end else if (ev.sck_fall && ev.sl_low) begin
            if (cnt == CNT_W'(HDR_W) && hdr.rnw && !hdr.test) begin
                sh <= rd_word;
                oe <= 1'b1;
            end else if (oe) begin
                sh <= sh >> 1;
            end
        end
    end

    assign sdo = oe & sh[0];

endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
    import scfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sck,
    input  logic                       sl,
    input  logic                       sdata_in,
    output logic                       sdata_out,
    output logic                       sdata_oe,
    output logic [NUM_REGS*DATA_W-1:0] cfg_q
);
    sev_t             ev;
    hdr_t             hdr;
    word_t            shadow;
    word_t            rd_word;
    logic [CNT_W-1:0] cnt;

    scfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk), .rst (rst), .sck (sck), .sl (sl), .sdi (sdata_in), .ev (ev)
    );

    scfg_frame u_frame (
        .clk (clk), .rst (rst), .ev (ev), .hdr (hdr), .shadow (shadow), .cnt (cnt)
    );

    scfg_regbank u_bank (
        .clk (clk), .rst (rst), .ev (ev), .hdr (hdr), .shadow (shadow), .cnt (cnt),
        .rd_word (rd_word), .cfg_q (cfg_q)
    );

    scfg_readout u_rd (
        .clk (clk), .rst (rst), .ev (ev), .hdr (hdr), .cnt (cnt), .rd_word (rd_word),
        .sdo (sdata_out), .oe (sdata_oe)
    );

endmodule

// File: rtl/scfg_checker.sv
module scfg_checker
    import scfg_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic [NUM_REGS*DATA_W-1:0] cfg_q,
    input logic                       sdata_out,
    input logic                       sdata_oe,
    input sev_t                       ev,
    input logic [CNT_W-1:0]           cnt
);
    // R5: fixed bits of register 0
    a_r5_op_fixed: assert property (@(posedge clk) disable iff (rst)
        cfg_q[7] && !cfg_q[6] && cfg_q[10:8] == 3'b000);

    // R4: bits outside each field stay zero
    a_r4_field_width: assert property (@(posedge clk) disable iff (rst)
        !cfg_q[DATA_W + 10] &&
        cfg_q[2*DATA_W + 10 -: 3] == '0 &&
        cfg_q[4*DATA_W + 10 -: 5] == '0 && cfg_q[5*DATA_W + 10 -: 5] == '0 &&
        cfg_q[6*DATA_W + 10 -: 5] == '0 && cfg_q[7*DATA_W + 10 -: 5] == '0);

    // R3: live registers move only on a load rising edge
    a_r3_commit_on_load: assert property (@(posedge clk) disable iff (rst)
        !ev.sl_rise |=> $stable(cfg_q));

    // R6: an incomplete frame commits nothing
    a_r6_short_frame: assert property (@(posedge clk) disable iff (rst)
        (ev.sl_rise && cnt != CNT_W'(FRAME_LEN)) |=> $stable(cfg_q));

    // R9: released output is quiet
    a_r9_released_zero: assert property (@(posedge clk) disable iff (rst)
        !sdata_oe |-> !sdata_out);

    // R9: enable drops when the load line rises
    a_r9_oe_drop: assert property (@(posedge clk) disable iff (rst)
        ev.sl_rise |=> !sdata_oe);

    // R8: drive starts only at a falling serial-clock edge
    a_r8_oe_start: assert property (@(posedge clk) disable iff (rst)
        $rose(sdata_oe) |-> $past(ev.sck_fall));

endmodule

bind serial_cfg_port scfg_checker u_chk (
    .clk (clk), .rst (rst), .cfg_q (cfg_q), .sdata_out (sdata_out),
    .sdata_oe (sdata_oe), .ev (ev), .cnt (cnt)
);

// File: tb/serial_cfg_port_bench.sv
module serial_cfg_port_bench;

    localparam int NR = 8;
    localparam int DW = 11;
    localparam int HP = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck_i = 1'b0;
    logic sl_i = 1'b1;
    logic sdi_i = 1'b0;
    logic sdata_out;
    logic sdata_oe;
    logic [NR*DW-1:0] cfg_q;

    int compared = 0;
    int mismatched = 0;

    always #10 clk = ~clk;

    serial_cfg_port u_serial_cfg_port (
        .clk (clk), .rst (rst), .sck (sck_i), .sl (sl_i), .sdata_in (sdi_i),
        .sdata_out (sdata_out), .sdata_oe (sdata_oe), .cfg_q (cfg_q)
    );

    // ---------------- behavioural reference ----------------
    function automatic logic [10:0] ref_keep(int a);
        case (a)
            0: return 11'h03F;
            1: return 11'h3FF;
            2: return 11'h0FF;
            3: return 11'h7FF;
            default: return 11'h03F;
        endcase
    endfunction

    logic [10:0] m_live [NR];
    logic [2:0]  hist [4];           // {sdi, sl, sck}, index = edges ago
    int          m_cnt;
    logic [4:0]  m_hdr;
    logic [10:0] m_dat;
    logic [10:0] m_sh;
    logic        m_oe;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) hist[i] = 3'b010;
            for (int i = 0; i < NR; i++) m_live[i] = (i == 0) ? 11'h080 : 11'h000;
            m_cnt = 0; m_hdr = '0; m_dat = '0; m_sh = '0; m_oe = 1'b0;
        end else begin
            logic [2:0] nw, od;
            bit ck_r, ck_f, ld_r, ld_f, ld_low;
            int a;
            for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = {sdi_i, sl_i, sck_i};
            nw = hist[2]; od = hist[3];
            ck_r = nw[0] && !od[0];
            ck_f = !nw[0] && od[0];
            ld_r = nw[1] && !od[1];
            ld_f = !nw[1] && od[1];
            ld_low = !nw[1];
            a = int'(m_hdr[2:0]);
            // read side
            if (ld_r || ld_f) begin
                m_oe = 1'b0; m_sh = '0;
            end else if (ck_f && ld_low) begin
                if (m_cnt == 5 && m_hdr[3] && !m_hdr[4]) begin
                    m_sh = m_live[a]; m_oe = 1'b1;
                end else if (m_oe) m_sh = m_sh >> 1;
            end
            // commit
            if (ld_r && m_cnt == 16 && !m_hdr[3] && !m_hdr[4])
                m_live[a] = (m_dat & ref_keep(a)) | ((a == 0) ? 11'h080 : 11'h000);
            // capture
            if (ld_f) m_cnt = 0;
            else if (ck_r && ld_low && m_cnt < 16) begin
                if (m_cnt < 5) m_hdr[m_cnt] = nw[2];
                else           m_dat[m_cnt-5] = nw[2];
                m_cnt++;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            logic [NR*DW-1:0] flat;
            for (int i = 0; i < NR; i++) flat[i*DW +: DW] = m_live[i];
            compared++;
            if (cfg_q !== flat) begin
                mismatched++;
                $display("FAIL R2 R3 R4 cfg_q per-clock: actual %h expected %h", cfg_q, flat);
            end
            compared++;
            if (sdata_oe !== m_oe) begin
                mismatched++;
                $display("FAIL R9 sdata_oe per-clock: actual %b expected %b", sdata_oe, m_oe);
            end
            compared++;
            if (sdata_out !== (m_oe & m_sh[0])) begin
                mismatched++;
                $display("FAIL R8 sdata_out per-clock: actual %b expected %b", sdata_out, m_oe & m_sh[0]);
            end
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic wclk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [10:0] reg_of(int a);
        return cfg_q[a*DW +: DW];
    endfunction

    // sends nb bits with load held low; leaves load low
    task automatic send(int addr, bit rnw, bit tst, logic [15:0] data, int nb,
                        output logic [10:0] rd);
        rd = '0;
        sl_i = 1'b0;
        wclk(HP);
        for (int i = 0; i < nb; i++) begin
            sck_i = 1'b0;
            if (i < 3)       sdi_i = addr[i];
            else if (i == 3) sdi_i = rnw;
            else if (i == 4) sdi_i = tst;
            else             sdi_i = data[i-5];
            wclk(HP);
            if (i >= 5 && i < 16) rd[i-5] = sdata_out;
            sck_i = 1'b1;
            wclk(HP);
        end
        sck_i = 1'b0;
        sdi_i = 1'b0;
        wclk(HP);
    endtask

    task automatic load();
        sl_i = 1'b1;
        wclk(8);
    endtask

    task automatic write(int addr, logic [15:0] data);
        logic [10:0] d;
        send(addr, 1'b0, 1'b0, data, 16, d);
        load();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin : main
        logic [10:0] rd;
        wclk(5);
        rst = 1'b0;
        wclk(3);

        // R1 reset contents
        check("R1 reg0", 32'(reg_of(0)), 32'h080);
        for (int i = 1; i < NR; i++) check("R1 regN", 32'(reg_of(i)), 32'h0);
        check("R1 oe", 32'(sdata_oe), 32'h0);

        // R3 / R2 / R9: write held before load
        send(3, 1'b0, 1'b0, 16'h05A5, 16, rd);
        check("R3 no change before load", 32'(reg_of(3)), 32'h0);
        check("R9 oe low in write frame", 32'(sdata_oe), 32'h0);
        load();
        check("R2 write reg3", 32'(reg_of(3)), 32'h5A5);

        write(6, 16'h002A);
        check("R2 write reg6", 32'(reg_of(6)), 32'h02A);
        check("R2 reg3 untouched", 32'(reg_of(3)), 32'h5A5);

        // R4 field widths
        write(1, 16'h07FF);
        check("R4 reg1 10 bits", 32'(reg_of(1)), 32'h3FF);
        write(2, 16'h07FF);
        check("R4 reg2 8 bits", 32'(reg_of(2)), 32'h0FF);
        write(4, 16'h07FF);
        check("R4 reg4 6 bits", 32'(reg_of(4)), 32'h03F);

        // R5 operation register fixed bits
        write(0, 16'h07FF);
        check("R5 reg0 all ones", 32'(reg_of(0)), 32'h0BF);
        write(0, 16'h0000);
        check("R5 reg0 zeros", 32'(reg_of(0)), 32'h080);

        // R6 short frame
        write(5, 16'h0011);
        send(5, 1'b0, 1'b0, 16'h002E, 15, rd);
        load();
        check("R6 short frame discarded", 32'(reg_of(5)), 32'h011);

        // R7 test flag set
        send(5, 1'b0, 1'b1, 16'h0015, 16, rd);
        load();
        check("R7 test write discarded", 32'(reg_of(5)), 32'h011);
        send(3, 1'b1, 1'b1, 16'h0000, 16, rd);
        check("R7 test read not driven", 32'(sdata_oe), 32'h0);
        check("R7 test read data", 32'(rd), 32'h0);
        load();

        // R8 / R9 readback
        send(3, 1'b1, 1'b0, 16'h0000, 16, rd);
        check("R8 read reg3", 32'(rd), 32'h5A5);
        check("R9 oe high in read", 32'(sdata_oe), 32'h1);
        load();
        check("R9 oe low after load", 32'(sdata_oe), 32'h0);
        check("R8 read leaves reg3", 32'(reg_of(3)), 32'h5A5);
        send(0, 1'b1, 1'b0, 16'h0000, 16, rd);
        load();
        check("R8 read reg0", 32'(rd), 32'h080);

        // R10 extra clocks ignored
        send(7, 1'b0, 1'b0, 16'h181B, 18, rd);
        load();
        check("R10 over-long frame", 32'(reg_of(7)), 32'h01B);

        wclk(10);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule